// File: doc/BRIEF.md
# Serial Page-Buffer Write Front End

This block is the receive side of a serial memory's command interface, restricted to the command that loads an on-chip SRAM page buffer. A host drives an active-low chip select, a serial clock and a data-in line in SPI mode 0, so bits are sampled on the rising clock edge. Each transaction starts with a one-byte opcode that picks one of the page buffers. Three address bytes follow, and then any number of data bytes. The data bytes are stored into the chosen buffer at consecutive offsets, and the offset wraps back to the start of the buffer when it passes the end.

The serial pins are oversampled by a fast system clock through a synchronizer and a rising-edge detector. A shifter assembles bytes from the sampled bits. A command controller walks through opcode, address and data phases. A buffer bank holds one or two byte arrays. A combinational read port returns any stored byte, so the contents can be checked or used downstream. Raising chip select ends a command at any point and returns the controller to its idle state.

Top module: `spi_pbw_top`

## Requirements
- R1: Opcode 0x84 writes into buffer 1, which is read with `rd_sel`=0. Opcode 0x87 writes into buffer 2, which is read with `rd_sel`=1.
- R2: The three bytes after the opcode form a 24-bit address, highest byte first. The start offset is the low OFS_W = ceil(log2(BUF_BYTES)) bits of that address, taken modulo BUF_BYTES (default 264). All higher bits are ignored.
- R3: Each byte is sampled on rising serial-clock edges while chip select is low, most-significant bit first.
- R4: Data byte k of a transaction is stored at (start + k) mod BUF_BYTES, so writing continues at offset 0 after offset BUF_BYTES-1.
- R5: A byte is stored only after all 8 of its bits have arrived. Bits of an incomplete byte pending when chip select rises are dropped.
- R6: Chip select going high ends the command and clears the bit count and the command state. The next low period starts again with an opcode, even if the previous command stopped partway through its address.
- R7: With NUM_BUFS=1, opcode 0x87 is unsupported and its transaction changes no stored byte.
- R8: An opcode other than the supported ones causes every remaining byte of that transaction to be ignored, including bytes equal to a valid opcode.
- R9: After reset every byte of every buffer reads 0.
- R10: `rd_data` shows the byte at `rd_addr` of the buffer picked by `rd_sel` in the same cycle. An `rd_addr` of BUF_BYTES or more returns 0. With NUM_BUFS=1, `rd_sel` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| rd_sel | input | 1 | Buffer picked for read-back (0 = buffer 1) |
| rd_addr | input | OFS_W | Byte offset for read-back |
| rd_data | output | 8 | Byte read from the selected buffer |

## Verification
Two instances run side by side on the same serial pins, one with two buffers and one with a single buffer. Every transaction therefore also shows whether 0x87 is refused only when the second buffer is absent. Directed transactions cover several cases:
- start offsets near the buffer end, which shows wrapping apart from spilling past the end;
- addresses whose low bits exceed the buffer size and whose page bits are nonzero;
- asymmetric data bytes such as 0x80 and 0x01, which reveal bit-order errors;
- a trailing partial byte;
- a select raised mid-address, followed at once by a fresh command;
- an unknown opcode followed by bytes that look like a valid command.

Random transactions with random opcodes, addresses, lengths and partial tails are then checked against a byte-level reference model, comparing both buffers in full.

// File: rtl/spi_pbw_pkg.sv
package spi_pbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_ADDR   = 3'd2,
        ST_DATA   = 3'd3,
        ST_IGNORE = 3'd4
    } cmd_state_e;

    localparam logic [7:0] OP_LOAD_BUF1 = 8'h84;
    localparam logic [7:0] OP_LOAD_BUF2 = 8'h87;
    localparam int         ADDR_BYTES   = 3;

endpackage

// File: rtl/spi_pbw_sync.sv
module spi_pbw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_idle_o,
    output logic sck_rise_o,
    output logic mosi_o
);
    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] mosi;
        logic              sck_last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.cs       = {s_q.cs[STAGES-2:0], cs_n_i};
        s_d.sck      = {s_q.sck[STAGES-2:0], sck_i};
        s_d.mosi     = {s_q.mosi[STAGES-2:0], mosi_i};
        s_d.sck_last = s_q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cs       <= '1;
            s_q.sck      <= '0;
            s_q.mosi     <= '0;
            s_q.sck_last <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_idle_o  = s_q.cs[STAGES-1];
    assign sck_rise_o = s_q.sck[STAGES-1] & ~s_q.sck_last;
    assign mosi_o     = s_q.mosi[STAGES-1];

    // R3: a detected rising edge is a single-cycle pulse
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise_o |=> !sck_rise_o);

endmodule

// File: rtl/spi_pbw_shifter.sv
module spi_pbw_shifter #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 sample_i,
    input  logic                 bit_i,
    output logic                 byte_valid_o,
    output logic [BYTE_BITS-1:0] byte_o
);
    localparam int CNT_W = $clog2(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    typedef struct packed {
        logic [BYTE_BITS-1:0] sh;
        logic [CNT_W-1:0]     cnt;
    } shf_t;

    shf_t f_d, f_q;

    always_comb begin
        f_d          = f_q;
        byte_valid_o = 1'b0;
        byte_o       = {f_q.sh[BYTE_BITS-2:0], bit_i};
        if (clear_i) begin
            f_d.sh  = '0;
            f_d.cnt = '0;
        end else if (sample_i) begin
            f_d.sh = {f_q.sh[BYTE_BITS-2:0], bit_i};
            if (f_q.cnt == LAST_BIT) begin
                f_d.cnt      = '0;
                byte_valid_o = 1'b1;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    // R5/R6: an idle select leaves no partial bits counted
    p_clear_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (f_q.cnt == '0));

    // R5: a byte completes only on a sampled bit
    p_byte_on_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> (sample_i && !clear_i));

endmodule

// File: rtl/spi_pbw_ctrl.sv
module spi_pbw_ctrl
    import spi_pbw_pkg::*;
#(
    parameter int BUF_BYTES = 264,
    parameter int NUM_BUFS  = 2,
    parameter int OFS_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    output logic             wr_en_o,
    output logic             wr_sel_o,
    output logic [OFS_W-1:0] wr_ofs_o,
    output logic [7:0]       wr_data_o
);
    localparam int CNT_W = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BYTES - 1);
    localparam int ACC_W = 8 * (ADDR_BYTES - 1);

    typedef struct packed {
        cmd_state_e       st;
        logic             sel;
        logic [CNT_W-1:0] acnt;
        logic [ACC_W-1:0] acc;
        logic [OFS_W-1:0] ofs;
    } ctl_t;

    ctl_t c_d, c_q;

    function automatic logic [OFS_W-1:0] reduce_ofs(input logic [OFS_W-1:0] raw);
        logic [31:0] wide;
        wide = 32'(raw) % 32'(BUF_BYTES);
        return wide[OFS_W-1:0];
    endfunction

    function automatic logic [OFS_W-1:0] next_ofs(input logic [OFS_W-1:0] cur);
        if (32'(cur) == BUF_BYTES - 1) begin
            return '0;
        end
        return cur + 1'b1;
    endfunction

    always_comb begin
        c_d       = c_q;
        wr_en_o   = 1'b0;
        wr_sel_o  = c_q.sel;
        wr_ofs_o  = c_q.ofs;
        wr_data_o = byte_i;
        if (idle_i) begin
            c_d.st   = ST_IDLE;
            c_d.acnt = '0;
        end else begin
            unique case (c_q.st)
                ST_IDLE, ST_OPCODE: begin
                    c_d.st = ST_OPCODE;
                    if (byte_valid_i) begin
                        c_d.acnt = '0;
                        if (byte_i == OP_LOAD_BUF1) begin
                            c_d.sel = 1'b0;
                            c_d.st  = ST_ADDR;
                        end else if ((byte_i == OP_LOAD_BUF2) && (NUM_BUFS > 1)) begin
                            c_d.sel = 1'b1;
                            c_d.st  = ST_ADDR;
                        end else begin
                            c_d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR: begin
                    if (byte_valid_i) begin
                        c_d.acc  = {c_q.acc[ACC_W-9:0], byte_i};
                        c_d.acnt = c_q.acnt + 1'b1;
                        if (c_q.acnt == LAST_ADDR) begin
                            c_d.ofs = reduce_ofs(OFS_W'({c_q.acc, byte_i}));
                            c_d.st  = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_valid_i) begin
                        wr_en_o = 1'b1;
                        c_d.ofs = next_ofs(c_q.ofs);
                    end
                end
                ST_IGNORE: c_d.st = ST_IGNORE;
                default:   c_d.st = ST_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st   <= ST_IDLE;
            c_q.sel  <= 1'b0;
            c_q.acnt <= '0;
            c_q.acc  <= '0;
            c_q.ofs  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // R6: raising the select returns the command machine to idle
    p_idle_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> (c_q.st == ST_IDLE));

    // R2: the running offset always lies inside the buffer
    p_ofs_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_DATA) |-> (32'(c_q.ofs) < BUF_BYTES));

    // R4: a write at the last location continues at location 0
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && (32'(wr_ofs_o) == BUF_BYTES - 1) && !idle_i) |=> (c_q.ofs == '0));

    // R4: otherwise a write advances the offset by one
    p_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && (32'(wr_ofs_o) != BUF_BYTES - 1)) |=> (c_q.ofs == $past(c_q.ofs) + 1'b1));

    // R8: an ignored command stays ignored while the select is low
    p_ignore_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_IGNORE) && !idle_i) |=> (c_q.st == ST_IGNORE));

    // R7: without a second buffer nothing targets it
    p_single_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && (NUM_BUFS == 1)) |-> !wr_sel_o);

endmodule

// File: rtl/spi_pbw_bufmem.sv
module spi_pbw_bufmem #(
    parameter int BUF_BYTES = 264,
    parameter int NUM_BUFS  = 2,
    parameter int OFS_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [OFS_W-1:0] wr_ofs_i,
    input  logic [7:0]       wr_data_i,
    input  logic             rd_sel_i,
    input  logic [OFS_W-1:0] rd_addr_i,
    output logic [7:0]       rd_data_o
);
    logic [7:0] bank_rd [NUM_BUFS];
    logic       rd_in_range;

    assign rd_in_range = (32'(rd_addr_i) < BUF_BYTES);

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
        logic [7:0] mem_d [BUF_BYTES];
        logic [7:0] mem_q [BUF_BYTES];

        always_comb begin
            mem_d = mem_q;
            if (wr_en_i && (32'(wr_sel_i) == g)) begin
                mem_d[wr_ofs_i] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < BUF_BYTES; i++) begin
                    mem_q[i] <= '0;
                end
            end else begin
                mem_q <= mem_d;
            end
        end

        assign bank_rd[g] = rd_in_range ? mem_q[rd_addr_i] : 8'h00;
    end

    if (NUM_BUFS > 1) begin : g_rd_two
        assign rd_data_o = rd_sel_i ? bank_rd[1] : bank_rd[0];
    end else begin : g_rd_one
        logic unused_sel;
        assign unused_sel = rd_sel_i;
        assign rd_data_o  = bank_rd[0];
    end

    // R4: the write port never addresses past the buffer end
    p_wr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (32'(wr_ofs_i) < BUF_BYTES));

    // R10: an out-of-range read offset returns zero
    p_rd_oob_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_in_range |-> (rd_data_o == 8'h00));

endmodule

// File: rtl/spi_pbw_top.sv
module spi_pbw_top #(
    parameter int BUF_BYTES = 264,
    parameter int NUM_BUFS  = 2,
    parameter int SYNC_STG  = 2,
    parameter int OFS_W     = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    input  logic             rd_sel,
    input  logic [OFS_W-1:0] rd_addr,
    output logic [7:0]       rd_data
);
    logic             cs_idle;
    logic             sck_rise;
    logic             mosi_s;
    logic             byte_valid;
    logic [7:0]       byte_val;
    logic             wr_en;
    logic             wr_sel;
    logic [OFS_W-1:0] wr_ofs;
    logic [7:0]       wr_data;

    spi_pbw_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (spi_cs_n),
        .sck_i      (spi_sck),
        .mosi_i     (spi_mosi),
        .cs_idle_o  (cs_idle),
        .sck_rise_o (sck_rise),
        .mosi_o     (mosi_s)
    );

    spi_pbw_shifter #(.BYTE_BITS(8)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (cs_idle),
        .sample_i     (sck_rise),
        .bit_i        (mosi_s),
        .byte_valid_o (byte_valid),
        .byte_o       (byte_val)
    );

    spi_pbw_ctrl #(
        .BUF_BYTES (BUF_BYTES),
        .NUM_BUFS  (NUM_BUFS),
        .OFS_W     (OFS_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_i       (cs_idle),
        .byte_valid_i (byte_valid),
        .byte_i       (byte_val),
        .wr_en_o      (wr_en),
        .wr_sel_o     (wr_sel),
        .wr_ofs_o     (wr_ofs),
        .wr_data_o    (wr_data)
    );

    spi_pbw_bufmem #(
        .BUF_BYTES (BUF_BYTES),
        .NUM_BUFS  (NUM_BUFS),
        .OFS_W     (OFS_W)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_ofs_i  (wr_ofs),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    // R6: no buffer write happens while the select is high
    p_no_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |-> !wr_en);

endmodule

// File: tb/tb_spi_pbw_top.sv
module tb_spi_pbw_top;
    localparam int BUF   = 264;
    localparam int OFS_W = $clog2(BUF);
    localparam int WDOG  = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1;
    logic             sck = 1'b0;
    logic             mosi = 1'b0;
    logic             rd_sel = 1'b0;
    logic [OFS_W-1:0] rd_addr = '0;
    logic [7:0]       rd_data;
    logic [7:0]       rd_data1;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0] m2 [0:1][0:BUF-1];
    logic [7:0] m1 [0:BUF-1];

    always #5 clk = ~clk;

    spi_pbw_top #(.BUF_BYTES(BUF), .NUM_BUFS(2)) dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    spi_pbw_top #(.BUF_BYTES(BUF), .NUM_BUFS(1)) dut1 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data1)
    );

    function automatic int start_ofs(input logic [23:0] addr);
        return int'(addr[OFS_W-1:0]) % BUF;
    endfunction

    function automatic logic [7:0] pat_byte(input int k);
        case (k % 3)
            0:       return 8'h80;
            1:       return 8'h01;
            default: return 8'hA5;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input string where);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, where, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            repeat (3) @(negedge clk);
            sck = 1'b1;
            repeat (3) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sel_low();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic sel_high();
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // full transaction; models both instances
    task automatic txn(input logic [7:0] op, input logic [23:0] addr, input int n,
                       input int tail, input bit pat);
        int o;
        logic [7:0] d;
        o = start_ofs(addr);
        sel_low();
        send_bits(op, 8);
        send_bits(addr[23:16], 8);
        send_bits(addr[15:8], 8);
        send_bits(addr[7:0], 8);
        for (int k = 0; k < n; k++) begin
            d = pat ? pat_byte(k) : 8'($urandom);
            send_bits(d, 8);
            if (op == 8'h84) begin
                m2[0][o] = d;
                m1[o]    = d;
            end else if (op == 8'h87) begin
                m2[1][o] = d;
            end
            o = (o + 1) % BUF;
        end
        if (tail > 0) send_bits(8'($urandom), tail);
        sel_high();
    endtask

    task automatic check_all(input string req2, input string req1);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < BUF; a++) begin
                @(negedge clk);
                rd_sel  = s[0];
                rd_addr = OFS_W'(a);
                #2;
                check(req2, rd_data, m2[s][a], $sformatf("dual buf%0d[%0d]", s, a));
                check(req1, rd_data1, m1[a], $sformatf("single buf[%0d] sel%0d", a, s));
            end
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < BUF; a++) m2[s][a] = 8'h00;
        for (int a = 0; a < BUF; a++) m1[a] = 8'h00;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: cleared after reset
        check_all("R9", "R9");

        // R1: buffer 1 and buffer 2 targets
        txn(8'h84, 24'h000000, 5, 0, 1'b0);
        // R2/R7: page bits set; single-buffer instance must ignore 0x87
        txn(8'h87, 24'hABC010, 6, 0, 1'b0);
        check_all("R1", "R7");

        // R4: wrap from 263 back to 0
        txn(8'h84, 24'h000104, 10, 0, 1'b0);
        // R2: low bits 511 reduce to 247
        txn(8'h87, 24'hFF01FF, 6, 0, 1'b0);
        check_all("R4", "R2");

        // R3: asymmetric bytes expose bit order
        txn(8'h84, 24'h000032, 6, 0, 1'b1);
        // R5: partial trailing byte dropped
        txn(8'h87, 24'h000005, 3, 5, 1'b0);
        txn(8'h84, 24'h00000A, 2, 7, 1'b0);
        check_all("R3", "R5");

        // R6: select raised mid-address, then a fresh command
        sel_low();
        send_bits(8'h84, 8);
        send_bits(8'h00, 8);
        send_bits(8'h00, 3);
        sel_high();
        txn(8'h84, 24'h000064, 4, 0, 1'b0);
        // R8: unknown opcode followed by a valid-looking command
        txn(8'h85, 24'h840000, 6, 0, 1'b0);
        check_all("R6", "R8");

        // R10: out-of-range read offset returns 0
        @(negedge clk);
        rd_sel  = 1'b1;
        rd_addr = OFS_W'(300);
        #2;
        check("R10", rd_data, 8'h00, "dual oob");
        check("R10", rd_data1, 8'h00, "single oob");

        // R1/R4: random mix
        for (int t = 0; t < 28; t++) begin
            int r;
            logic [7:0] op;
            r = int'($urandom % 8);
            op = (r < 3) ? 8'h84 : (r < 6) ? 8'h87 : 8'($urandom);
            txn(op, 24'($urandom), int'($urandom % 24), int'($urandom % 8), 1'b0);
        end
        check_all("R1", "R4");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule